// File: doc/BRIEF.md
# GPIO Port with Shared-Function Arbitration

This block controls a port of general-purpose pins. Software configures it through a small register bus that has a write strobe, an address, write data and combinational read data. For every pin the block holds an output latch, a direction bit and a pullup-request bit. Pin levels coming in from the pads are resynchronised through two flops before software can read them.

Each pin can also be claimed by a shared digital peripheral or by an analog function, and the block decides which source drives the pad. An analog claim wins over a peripheral claim, and a peripheral claim wins over plain GPIO. An analog claim switches off the output driver, the input buffer and the pullup. A peripheral claim takes over the pad's output value and output enable. Reads of the data register still follow the direction bit while a peripheral owns the pin. The pullup control is switched off automatically for any pin that is being driven.

Top module: `gpio_port`

## Requirements
- R1: After reset the output latch, direction and pullup registers are all 0. Every pad is then undriven (pad_oe 0) with its pullup off, and all three registers read 0.
- R2: Registers sit at bus offsets 0 (output latch), 1 (direction) and 2 (pullup request). Each is W bits wide. A write takes effect on the clock edge where bus_we is high. Offset 3 reads 0, and writes to offset 3 change no register.
- R3: If a pin has neither a peripheral nor an analog claim and its direction bit is 1, pad_oe is 1 and pad_out equals the latch bit. With direction 0 the pin is not driven.
- R4: Reading offset 0 returns, for each pin, the latch bit when its direction bit is 1 and the synchronised pad level when it is 0.
- R5: If a pin has a peripheral claim (per_en 1) and no analog claim, pad_out and pad_oe follow per_out and per_oe whatever the direction bit is. The offset-0 read still follows the direction bit as in R4.
- R6: If a pin has an analog claim (ana_en 1), pad_oe, pad_out and pad_ie are all 0. The offset-0 read of that pin gives 0 when its direction bit is 0 and the latch bit when it is 1.
- R7: If a pin has both an analog and a peripheral claim, the analog claim controls the pin exactly as in R6.
- R8: pull_en of a pin is 1 only when its pullup bit is 1, the pin has no analog claim, and the pin is not being driven. A pin counts as driven when it is a GPIO output or when a claiming peripheral enables the output.
- R9: A value written to the output latch while the pin is an input is held. It is the value driven on pad_out in the first cycle after the direction bit is set.
- R10: A change on pad_in shows up on the offset-0 read of an input pin after exactly two rising clock edges, and not after one.
- R11: per_in carries the synchronised pad level to the peripherals, and is forced to 0 for pins under an analog claim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data for bus_addr |
| pad_in | input | W | Raw pin levels from the pads |
| per_en | input | W | Per-pin shared peripheral claim |
| per_out | input | W | Peripheral output value |
| per_oe | input | W | Peripheral output enable |
| ana_en | input | W | Per-pin analog claim |
| per_in | output | W | Synchronised pin level to peripherals |
| pad_out | output | W | Pad output value |
| pad_oe | output | W | Pad output-buffer enable |
| pad_ie | output | W | Pad input-buffer enable |
| pull_en | output | W | Pad pullup enable |

## Verification
The assertions assume that pad_in, the claim vectors and the bus signals are stable around each rising edge. They also assume that bus_addr holds a value the read mux can decode. The latency check assumes pad_in changes no faster than the clock. The bench changes every input only on the falling edge and samples after the combinational outputs have settled. It holds pad_in steady for at least two edges before it reads the synchronised level.

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_we,
  input  logic [1:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic [W-1:0] pad_in,
  input  logic [W-1:0] per_en,
  input  logic [W-1:0] per_out,
  input  logic [W-1:0] per_oe,
  input  logic [W-1:0] ana_en,
  output logic [W-1:0] per_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_ie,
  output logic [W-1:0] pull_en
);
  localparam logic [1:0] OFS_DAT = 2'd0;
  localparam logic [1:0] OFS_DIR = 2'd1;
  localparam logic [1:0] OFS_PUE = 2'd2;

  logic [W-1:0] latch_q, dir_q, pue_q, meta_q, sync_q;
  logic [W-1:0] dig_claim, drv_oe, drv_val, seen_lvl, dat_view;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
      pue_q   <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        OFS_DAT: latch_q <= bus_wdata;
        OFS_DIR: dir_q   <= bus_wdata;
        OFS_PUE: pue_q   <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pad_in;
      sync_q <= meta_q;
    end
  end

  assign dig_claim = per_en & ~ana_en;
  assign drv_oe    = (dig_claim & per_oe) | (~per_en & ~ana_en & dir_q);
  assign drv_val   = (dig_claim & per_out) | (~per_en & ~ana_en & latch_q);

  assign pad_oe   = drv_oe;
  assign pad_out  = drv_val;
  assign pad_ie   = ~ana_en;
  assign seen_lvl = sync_q & ~ana_en;
  assign per_in   = seen_lvl;
  assign pull_en  = pue_q & ~ana_en & ~drv_oe;
  assign dat_view = (dir_q & latch_q) | (~dir_q & seen_lvl);

  always_comb begin
    case (bus_addr)
      OFS_DAT: bus_rdata = dat_view;
      OFS_DIR: bus_rdata = dir_q;
      OFS_PUE: bus_rdata = pue_q;
      default: bus_rdata = '0;
    endcase
  end

  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  p_ana_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ana_en & (pad_oe | pad_ie | pad_out)) == '0);

  p_ana_over_per_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ana_en & per_en & pad_oe) == '0);

  p_pull_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_en & (pad_oe | ana_en)) == '0);

  p_undef_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == 2'd3 |-> bus_rdata == '0);

  p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFS_DIR) |=> dir_q == $past(bus_wdata));

  p_periph_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((per_en & ~ana_en & (pad_oe ^ per_oe)) == '0));

  p_sync_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    warm_q >= 2'd2 |-> sync_q == $past(pad_in, 2));

  p_perin_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (per_in & ana_en) == '0);
endmodule

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
  localparam int W = 8;
  logic clk = 0, rst_n = 0, bus_we = 0;
  logic [1:0] bus_addr = 0;
  logic [W-1:0] bus_wdata = 0, bus_rdata, pad_in = 0, per_en = 0, per_out = 0,
                per_oe = 0, ana_en = 0, per_in, pad_out, pad_oe, pad_ie, pull_en;
  int nvec = 0, nbad = 0;

  gpio_port #(.W(W)) dut (.*);

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0; #1;
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic clr();
    wr(0, 0); wr(1, 0); wr(2, 0);
    per_en = 0; per_out = 0; per_oe = 0; ana_en = 0; pad_in = 0;
    repeat (3) @(negedge clk); #1;
  endtask

  task automatic t_reset();
    logic [W-1:0] v;
    chk("R1 pad_oe", pad_oe, 0); chk("R1 pull_en", pull_en, 0);
    rd(0, v); chk("R1 dat", v, 0); rd(1, v); chk("R1 dir", v, 0);
    rd(2, v); chk("R1 pue", v, 0);
  endtask

  task automatic t_regs();
    logic [W-1:0] v;
    wr(1, 8'h3C); wr(2, 8'hA5); wr(3, 8'hFF);
    rd(1, v); chk("R2 dir", v, 8'h3C); rd(2, v); chk("R2 pue", v, 8'hA5);
    rd(3, v); chk("R2 undef", v, 0);
    wr(1, 8'hFF); wr(0, 8'h96);
    rd(0, v); chk("R2 dat", v, 8'h96);
    clr();
  endtask

  task automatic t_gpio_out();
    wr(0, 8'h5A); wr(1, 8'h0F);
    chk("R3 oe", pad_oe, 8'h0F); chk("R3 out", pad_out & pad_oe, 8'h0A);
    clr();
  endtask

  task automatic t_readsrc();
    logic [W-1:0] v;
    wr(0, 8'hF0); wr(1, 8'hCC);
    @(negedge clk); pad_in = 8'h33; repeat (2) @(negedge clk); #1;
    rd(0, v); chk("R4 mixed read", v, 8'hC0 | 8'h33);
    clr();
  endtask

  task automatic t_periph();
    logic [W-1:0] v;
    wr(0, 8'hFF); wr(1, 8'h0F);
    @(negedge clk); per_en = 8'hFF; per_out = 8'h81; per_oe = 8'hF0; pad_in = 8'h55;
    repeat (2) @(negedge clk); #1;
    chk("R5 oe", pad_oe, 8'hF0); chk("R5 out", pad_out, 8'h81);
    rd(0, v); chk("R5 read by dir", v, 8'h0F | 8'h50);
    clr();
  endtask

  task automatic t_analog();
    logic [W-1:0] v;
    wr(0, 8'hFF); wr(1, 8'h0F); wr(2, 8'hFF);
    @(negedge clk); ana_en = 8'h3C; pad_in = 8'hFF;
    repeat (2) @(negedge clk); #1;
    chk("R6 oe", pad_oe, 8'h03); chk("R6 ie", pad_ie, 8'hC3);
    chk("R6 out", pad_out & ana_en, 0);
    rd(0, v); chk("R6 read", v, 8'hCF);
    chk("R11 per_in", per_in, 8'hC3);
    chk("R8 pull ana", pull_en, 8'hC0);
    clr();
  endtask

  task automatic t_ana_over_per();
    @(negedge clk); per_en = 8'hFF; per_oe = 8'hFF; per_out = 8'hFF; ana_en = 8'hF0; #1;
    chk("R7 oe", pad_oe, 8'h0F); chk("R7 out", pad_out, 8'h0F);
    chk("R7 ie", pad_ie, 8'h0F);
    clr();
  endtask

  task automatic t_pullup();
    wr(2, 8'hFF); chk("R8 all in", pull_en, 8'hFF);
    wr(1, 8'h03); chk("R8 gpio out", pull_en, 8'hFC);
    @(negedge clk); per_en = 8'h30; per_oe = 8'h10; #1;
    chk("R8 periph", pull_en, 8'hEC);
    clr();
  endtask

  task automatic t_preload();
    wr(0, 8'hA5); chk("R9 idle", pad_oe, 0);
    wr(1, 8'hFF); chk("R9 drive", pad_out, 8'hA5);
    clr();
  endtask

  task automatic t_sync();
    logic [W-1:0] v;
    @(negedge clk); pad_in = 8'h69;
    @(negedge clk); #1; rd(0, v); chk("R10 one edge", v, 0);
    @(negedge clk); #1; rd(0, v); chk("R10 two edges", v, 8'h69);
    chk("R11 per_in", per_in, 8'h69);
    clr();
  endtask

  initial begin
    repeat (2) @(negedge clk); #1;
    t_reset();
    rst_n = 1;
    @(negedge clk); #1;
    t_regs(); t_gpio_out(); t_readsrc(); t_periph(); t_analog();
    t_ana_over_per(); t_pullup(); t_preload(); t_sync();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    #200000;
    nvec++; nbad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule